// File: doc/BRIEF.md
# Buffered Result Readout Port With Busy Flag

This block is the host-facing serial read port of a converter isolator. A fetch engine on the far side of the chip delivers converter results as pairs of words (one word for lane A, one for lane B), each pair marked by a one-cycle load strobe. The block collects the words of one conversion in a staging register. It then moves the complete set into a buffer. From the buffer the host shifts the set out over two serial data lines at once, one per lane, under its own chip select and serial clock.

A busy output tells the host when to read. It rises on the rising edge of the host's conversion-start pin and falls only once every word of that conversion has reached the buffer. The host may stop at any bit and may read the same buffer as many times as it likes. If a set completes while the host is reading, it waits in staging until chip select goes high, so a read in progress never sees a mix of old and new bits. All host pins are sampled by the block clock, so the host serial clock may run far slower than the block clock.

Top module: `result_spi_slave`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, busy is low and both data lines are low. The buffer resets to all zeros, so a read taken before any conversion returns zero bits.
- R2: Busy goes high no later than 3 block-clock cycles after a rising edge of `conv_start`.
- R3: After a conversion start, busy stays high until NWORDS load strobes have been captured. With chip select high, it falls 1 cycle after the last strobe.
- R4: When `cs_n` has been high for 3 cycles, both `miso_a` and `miso_b` are driven low. They are never left floating.
- R5: No more than 3 cycles after `cs_n` falls, each line shows the MSB of its buffered set, before any SCK edge. Each falling SCK edge then moves the line to the next lower bit. SCK idles low and the host samples on the rising edge.
- R6: Lane A carries the words loaded on `res_a` and lane B the words loaded on `res_b`. The two lanes shift out at the same time.
- R7: Within one chip-select window the first-loaded word comes out first, MSB first, and the next word follows with no gap. Once all NWORDS*WORD_W bits have been shifted, the lines stay low.
- R8: Raising `cs_n` after any number of bits ends the read. The next low `cs_n` starts again at the MSB of the same buffered set.
- R9: If a set completes while `cs_n` is low, the lines go on shifting the old set and busy stays high. Within 3 cycles of `cs_n` going high the new set is buffered and busy falls.
- R10: Busy reacts only to the rising edge of `conv_start`. Holding the pin high does not keep busy high once the set is buffered.
- R11: Load strobes that arrive while busy is low are ignored, and the buffer does not change.
- R12: Reads are correct for SCK half periods from 4 up to at least 64 block-clock cycles.
- R13: A new conversion start that arrives before a set is complete throws away the partial words. The next NWORDS strobes form the buffered set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Host conversion start; the rising edge is used |
| cs_n | input | 1 | Host chip select, active low |
| sck | input | 1 | Host serial clock, idle low |
| res_load | input | 1 | One-cycle strobe: res_a and res_b carry the next word |
| res_a | input | WORD_W | Result word for lane A |
| res_b | input | WORD_W | Result word for lane B |
| miso_a | output | 1 | Serial data for lane A |
| miso_b | output | 1 | Serial data for lane B |
| busy | output | 1 | High from conversion start until fresh results are buffered |

## Verification
The two lanes are loaded with words of different bit patterns. A swap between the lanes or between the words, a reversed bit order, or a missing word boundary therefore shows up as a wrong bit. Full reads run past the end of the set to show the trailing zeros. Partial reads followed by a fresh read separate a restart from the MSB from a read that carries on where it stopped. A conversion whose last word arrives during a read shows whether the commit waits for chip select. A read with a very slow SCK, stray strobes while idle, a conversion-start pin held high and a restarted conversion cover the rest of the requirements.

// File: rtl/rss_pkg.sv
package rss_pkg;

    // Two result lanes, A at index 0 and B at index 1.
    localparam int NLANES    = 2;

    // Host pin positions inside the synchroniser vector.
    localparam int HOST_PINS = 3;
    localparam int PIN_CS    = 0;
    localparam int PIN_SCK   = 1;
    localparam int PIN_CNV   = 2;

    // Reset value of each host pin: chip select idles high, the rest low.
    localparam logic [HOST_PINS-1:0] HOST_IDLE = 3'b001;

    // One-cycle events taken from the synchronised host pins.
    typedef struct packed {
        logic conv_rise;
        logic sck_fall;
        logic cs_fall;
    } host_evt_t;

    // Progress of the result set through staging.
    typedef enum logic [1:0] {
        STG_READY   = 2'd0,
        STG_COLLECT = 2'd1,
        STG_HELD    = 2'd2
    } stage_e;

    // Width of a counter that has to reach n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rss_sync.sv
module rss_sync #(
    parameter int                 WIDTH    = 3,
    parameter int                 STAGES   = 2,
    parameter logic [WIDTH-1:0]   IDLE_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE_VAL}};
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign lvl = chain_q[STAGES-1];

endmodule

// File: rtl/rss_edge_det.sv
module rss_edge_det
    import rss_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [HOST_PINS-1:0] lvl,
    output host_evt_t            evt
);

    logic [HOST_PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= HOST_IDLE;
        else     prev_q <= lvl;
    end

    always_comb begin
        evt.conv_rise =  lvl[PIN_CNV] & ~prev_q[PIN_CNV];
        evt.sck_fall  = ~lvl[PIN_SCK] &  prev_q[PIN_SCK];
        evt.cs_fall   = ~lvl[PIN_CS]  &  prev_q[PIN_CS];
    end

endmodule

// File: rtl/rss_result_stage.sv
module rss_result_stage
    import rss_pkg::*;
#(
    parameter  int WORD_W = 24,
    parameter  int NWORDS = 2,
    localparam int SET_W  = WORD_W * NWORDS,
    localparam int CNT_W  = cnt_width(NWORDS)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            conv_rise,
    input  logic                            host_idle,
    input  logic                            load,
    input  logic [NLANES-1:0][WORD_W-1:0]   words,
    output logic                            busy,
    output logic [NLANES-1:0][SET_W-1:0]    set_q
);

    stage_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             take, commit, last_word;

    // A conversion start always restarts collection; otherwise strobes
    // fill the set and a full set waits for an idle chip select.
    always_comb begin
        last_word = (cnt_q == CNT_W'(NWORDS - 1));
        take      = 1'b0;
        commit    = 1'b0;
        state_d   = state_q;
        cnt_d     = cnt_q;
        if (conv_rise) begin
            state_d = STG_COLLECT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                STG_COLLECT: begin
                    if (load) begin
                        take  = 1'b1;
                        cnt_d = cnt_q + 1'b1;
                        if (last_word) state_d = STG_HELD;
                    end
                end
                STG_HELD: begin
                    if (host_idle) begin
                        commit  = 1'b1;
                        state_d = STG_READY;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STG_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // One staging and one buffer register per lane; the first word
    // loaded ends up in the most significant position.
    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [SET_W-1:0] stg_q;
        logic [SET_W-1:0] held_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                stg_q  <= '0;
                held_q <= '0;
            end else begin
                if (take)   stg_q  <= (stg_q << WORD_W) | SET_W'(words[l]);
                if (commit) held_q <= stg_q;
            end
        end

        assign set_q[l] = held_q;
    end

    assign busy = (state_q != STG_READY);

endmodule

// File: rtl/rss_lane_shifter.sv
module rss_lane_shifter #(
    parameter int SET_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_idle,
    input  logic             cs_fall,
    input  logic             sck_fall,
    input  logic [SET_W-1:0] set_word,
    output logic             miso
);

    logic [SET_W-1:0] sh_q;
    logic             armed_q;

    // The buffer is copied when chip select falls, so a later commit
    // cannot disturb a read that is already under way.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            armed_q <= 1'b0;
        end else if (cs_fall) begin
            sh_q    <= set_word;
            armed_q <= 1'b1;
        end else if (host_idle) begin
            armed_q <= 1'b0;
        end else if (armed_q && sck_fall) begin
            sh_q    <= sh_q << 1;
        end
    end

    assign miso = armed_q & sh_q[SET_W-1];

endmodule

// File: rtl/result_spi_slave.sv
module result_spi_slave
    import rss_pkg::*;
#(
    parameter  int WORD_W      = 24,
    parameter  int NWORDS      = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int SET_W       = WORD_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              res_load,
    input  logic [WORD_W-1:0] res_a,
    input  logic [WORD_W-1:0] res_b,
    output logic              miso_a,
    output logic              miso_b,
    output logic              busy
);

    logic [HOST_PINS-1:0]             host_raw;
    logic [HOST_PINS-1:0]             host_lvl;
    host_evt_t                        evt;
    logic                             cs_idle;
    logic                             conv_rise;
    logic                             sck_fall;
    logic                             cs_fall;
    logic [NLANES-1:0][WORD_W-1:0]    lane_words;
    logic [NLANES-1:0][SET_W-1:0]     set_q;
    logic [NLANES-1:0]                miso_v;

    always_comb begin
        host_raw          = '0;
        host_raw[PIN_CS]  = cs_n;
        host_raw[PIN_SCK] = sck;
        host_raw[PIN_CNV] = conv_start;
    end

    rss_sync #(
        .WIDTH    (HOST_PINS),
        .STAGES   (SYNC_STAGES),
        .IDLE_VAL (HOST_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (host_raw),
        .lvl (host_lvl)
    );

    rss_edge_det u_edge (
        .clk (clk),
        .rst (rst),
        .lvl (host_lvl),
        .evt (evt)
    );

    assign cs_idle   = host_lvl[PIN_CS];
    assign conv_rise = evt.conv_rise;
    assign sck_fall  = evt.sck_fall;
    assign cs_fall   = evt.cs_fall;

    assign lane_words = {res_b, res_a};

    rss_result_stage #(
        .WORD_W (WORD_W),
        .NWORDS (NWORDS)
    ) u_stage (
        .clk       (clk),
        .rst       (rst),
        .conv_rise (conv_rise),
        .host_idle (cs_idle),
        .load      (res_load),
        .words     (lane_words),
        .busy      (busy),
        .set_q     (set_q)
    );

    for (genvar l = 0; l < NLANES; l++) begin : g_shift
        rss_lane_shifter #(
            .SET_W (SET_W)
        ) u_shift (
            .clk       (clk),
            .rst       (rst),
            .host_idle (cs_idle),
            .cs_fall   (cs_fall),
            .sck_fall  (sck_fall),
            .set_word  (set_q[l]),
            .miso      (miso_v[l])
        );
    end

    assign miso_a = miso_v[0];
    assign miso_b = miso_v[1];

endmodule

// File: rtl/rss_chk.sv
module rss_chk #(
    parameter int SET_W = 48
) (
    input logic                             clk,
    input logic                             rst,
    input logic                             cs_n,
    input logic                             conv_rise,
    input logic                             sck_fall,
    input logic                             cs_fall,
    input logic                             cs_idle,
    input logic                             load,
    input logic                             busy,
    input logic                             miso_a,
    input logic                             miso_b,
    input logic [rss_pkg::NLANES*SET_W-1:0] set_flat
);

    // R1: first cycle after reset is quiet
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !miso_a && !miso_b));

    // R2: busy only rises after a conversion-start edge
    assert_busy_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(conv_rise));

    // R4: lines stay low while chip select has been high
    assert_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> (!miso_a && !miso_b));

    // R5: a data line only moves on an SCK fall or a chip-select change
    assert_miso_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(miso_a) || !$stable(miso_b)) |->
            ($past(sck_fall) || $past(cs_fall) || $past(cs_idle)));

    // R9: busy drops only when the host is not reading
    assert_busy_fall_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cs_idle));

    // R11: strobes while idle leave the buffer untouched
    assert_load_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (!busy && load) |=> $stable(set_flat));

endmodule

bind result_spi_slave rss_chk #(.SET_W(SET_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_n      (cs_n),
    .conv_rise (conv_rise),
    .sck_fall  (sck_fall),
    .cs_fall   (cs_fall),
    .cs_idle   (cs_idle),
    .load      (res_load),
    .busy      (busy),
    .miso_a    (miso_a),
    .miso_b    (miso_b),
    .set_flat  (set_q)
);

// File: tb/tb_result_spi_slave.sv
module tb_result_spi_slave;

    localparam int CLK_P  = 10;
    localparam int WORD_W = 24;
    localparam int NWORDS = 2;
    localparam int SET_W  = WORD_W * NWORDS;
    localparam int FAST   = 4;
    localparam int SLOW   = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              conv_start = 1'b0;
    logic              cs_n = 1'b1;
    logic              sck = 1'b0;
    logic              res_load = 1'b0;
    logic [WORD_W-1:0] res_a = '0;
    logic [WORD_W-1:0] res_b = '0;
    logic              miso_a, miso_b, busy;

    always #(CLK_P/2) clk = ~clk;

    result_spi_slave #(.WORD_W(WORD_W), .NWORDS(NWORDS)) dut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .cs_n(cs_n), .sck(sck),
        .res_load(res_load), .res_a(res_a), .res_b(res_b),
        .miso_a(miso_a), .miso_b(miso_b), .busy(busy)
    );

    typedef struct {
        logic  a;
        logic  b;
        string tag;
    } exp_t;

    exp_t             sb_q[$];
    event             samp_ev;
    int               checks = 0;
    int               errors = 0;
    logic [SET_W-1:0] mdl_a = '0;
    logic [SET_W-1:0] mdl_b = '0;

    task automatic check(bit ok, string req, string what,
                         longint unsigned act, longint unsigned expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Monitor: pops each expected bit pair when the driver marks a sample point.
    initial begin
        forever begin
            exp_t e;
            @(samp_ev);
            if (sb_q.size() == 0) begin
                check(1'b0, "SB", "queue empty at sample", 0, 1);
            end else begin
                e = sb_q.pop_front();
                check(miso_a === e.a && miso_b === e.b, e.tag, "miso {a,b}",
                      {miso_a, miso_b}, {e.a, e.b});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "run did not finish", 1, 0);
        report();
        $finish;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_sample(logic a, logic b, string tag);
        exp_t e;
        e.a = a; e.b = b; e.tag = tag;
        sb_q.push_back(e);
        -> samp_ev;
    endtask

    task automatic cs_open();
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_close();
        cs_n = 1'b1;
        tick(4);
    endtask

    // Driver: expects model bits start..start+n-1, MSB first, zeros past the set.
    task automatic clock_bits(int start, int n, int half, string tag);
        for (int i = 0; i < n; i++) begin
            int   k;
            logic ea, eb;
            k  = start + i;
            ea = 1'b0;
            eb = 1'b0;
            if (k < SET_W) begin
                ea = mdl_a[SET_W-1-k];
                eb = mdl_b[SET_W-1-k];
            end
            push_sample(ea, eb, tag);
            tick(1);
            sck = 1'b1; tick(half);
            sck = 1'b0; tick(half - 1);
        end
    endtask

    task automatic conv_pulse();
        conv_start = 1'b1;
        tick(4);
        conv_start = 1'b0;
    endtask

    task automatic load_word(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
        res_a = a; res_b = b; res_load = 1'b1;
        tick(1);
        res_load = 1'b0;
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(2);
        // R1: quiet after reset, buffer zero
        check(busy === 1'b0, "R1", "busy after reset", busy, 0);
        check(miso_a === 1'b0 && miso_b === 1'b0, "R1", "miso after reset", {miso_a, miso_b}, 0);
        cs_open();
        clock_bits(0, 8, FAST, "R1");
        cs_close();

        // R2, R3, R10: one conversion with two word pairs, start pin held high
        conv_start = 1'b1;
        tick(4);
        check(busy === 1'b1, "R2", "busy after start edge", busy, 1);
        load_word(24'hA5C3E1, 24'h3C5A78);
        tick(2);
        check(busy === 1'b1, "R3", "busy with one word", busy, 1);
        load_word(24'h0F1E2D, 24'hF0E1D2);
        tick(1);
        check(busy === 1'b0, "R3", "busy after last word", busy, 0);
        mdl_a = {24'hA5C3E1, 24'h0F1E2D};
        mdl_b = {24'h3C5A78, 24'hF0E1D2};
        tick(10);
        check(busy === 1'b0, "R10", "busy with start held high", busy, 0);
        conv_start = 1'b0;

        // R5, R6, R7: full read, word boundary, trailing zeros
        cs_open();
        clock_bits(0, SET_W + 4, FAST, "R7");
        cs_close();
        check(miso_a === 1'b0 && miso_b === 1'b0, "R4", "miso with cs high", {miso_a, miso_b}, 0);

        // R8: partial reads restart at the MSB
        cs_open();
        clock_bits(0, 10, FAST, "R8");
        cs_close();
        cs_open();
        clock_bits(0, 12, FAST, "R8");
        cs_close();

        // R11: strobes while idle are ignored
        load_word(24'h123456, 24'h654321);
        tick(2);
        check(busy === 1'b0, "R11", "busy after stray load", busy, 0);
        cs_open();
        clock_bits(0, 30, FAST, "R11");
        cs_close();

        // R9: set completes during a read
        cs_open();
        clock_bits(0, 5, FAST, "R9");
        conv_pulse();
        check(busy === 1'b1, "R9", "busy after start during read", busy, 1);
        load_word(24'h5A5A5A, 24'h00FF00);
        load_word(24'hC0FFEE, 24'h81C3E7);
        tick(3);
        check(busy === 1'b1, "R9", "busy with commit deferred", busy, 1);
        clock_bits(5, 8, FAST, "R9");
        cs_close();
        check(busy === 1'b0, "R9", "busy after cs high", busy, 0);
        mdl_a = {24'h5A5A5A, 24'hC0FFEE};
        mdl_b = {24'h00FF00, 24'h81C3E7};
        cs_open();
        clock_bits(0, SET_W, FAST, "R9");
        cs_close();

        // R12: slow serial clock
        cs_open();
        clock_bits(0, 30, SLOW, "R12");
        cs_close();

        // R13: restart before the set completes
        conv_pulse();
        load_word(24'hDEAD00, 24'hBEEF00);
        conv_pulse();
        check(busy === 1'b1, "R13", "busy after restart", busy, 1);
        load_word(24'h13579B, 24'h2468AC);
        tick(2);
        check(busy === 1'b1, "R13", "busy with one new word", busy, 1);
        load_word(24'hFEDCBA, 24'h0A0B0C);
        tick(1);
        check(busy === 1'b0, "R13", "busy after restarted set", busy, 0);
        mdl_a = {24'h13579B, 24'hFEDCBA};
        mdl_b = {24'h2468AC, 24'h0A0B0C};
        cs_open();
        clock_bits(0, SET_W, FAST, "R13");
        cs_close();

        tick(2);
        check(sb_q.size() == 0, "SB", "unconsumed expectations", sb_q.size(), 0);
        report();
        $finish;
    end

endmodule